// File: doc/BRIEF.md
# Disk Controller Host Register File

This block is the host-side register window of a disk controller that sits on an 8-bit I/O bus. An 8-bit I/O address is compared in its upper nibble against a 4-bit base setting; on a match, the low nibble picks one of sixteen ports. Reads and writes are steered to a set of task registers (sector count, sector number, a 10-bit cylinder, a packed size/drive/head byte), a read-only status port and a write-only command port at the same offset, an error register that shares its offset with a write-only precompensation register, three DMA address bytes and a control byte. Offset 0 is a data port into a 1 Kbyte sector buffer whose address pointer advances on every access.

The internal command processor is represented by a small side interface: it receives a one-cycle command pulse with the command code, and answers with a completion pulse that loads status flags and an error code, and with an interrupt pulse. The host clears a pending interrupt by reading status or by issuing a new command. An optional wait-state mode stretches every access to the window.

Top module: `dskhost_regif`

## Requirements
- R1: An access is taken only when io_addr[7:4] equals base_sel; an access outside the window changes no register, leaves io_rdata unchanged and raises no wait.
- R2: A read strobe at offset 1..7 returns, on the edge that samples the strobe, the error register (1), sector count (2), sector number (3), cylinder low (4), cylinder high (5), size/drive/head (6) and status (7); offsets 8 to 15 read as 0xFF.
- R3: Writes go to precompensation (1), the task registers (2..6), DMA address bytes low/middle/high (8, 9, 10 forming dma_addr[7:0], [15:8], [23:16]) and the control byte (11); writes to 12..15 change nothing, and the precompensation value is not readable at offset 1.
- R4: Every read or write at offset 0 accesses the sector buffer at the current pointer and then advances the pointer by one, wrapping from 1023 to 0.
- R5: An accepted command write returns the buffer pointer to 0.
- R6: A command write while idle gives a one-cycle cmd_go with cmd_code equal to the written byte and sets status bit 7 (busy) on the same edge.
- R7: While busy, writes to offsets 1..7 are ignored: task registers keep their values and no new command is issued.
- R8: A cp_done pulse clears busy, loads cp_flags[4:0] into status bits 6:2 (bit 6 ready, 5 write fault, 4 seek done, 3 data request, 2 corrected), loads cp_err into the error register and sets status bit 0 when cp_err is nonzero; status bit 1 reads 0.
- R9: A cp_irq pulse sets irq, which stays set until a status read or an accepted command write clears it; a cp_irq in the same cycle as a clearing event leaves irq set.
- R10: An accepted command write clears status bit 0.
- R11: Size/drive/head bit 7 drives ecc_sel; bits 6:5 give sec_len 00=256, 01=512, 10=1024, 11=128; bits 4:3 give drv_sel one-hot (bit n set for code n, code 3 being the floppy); bits 2:0 give head.
- R12: cyl equals {cylinder-high[1:0], cylinder-low}, and precomp_on is high exactly when cyl is at least four times the precompensation byte.
- R13: With wait_en high, each access in the window (unused offsets included) holds io_wait high for the two cycles after the strobe edge; with wait_en low io_wait stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_sel | input | 4 | Window base compared with io_addr[7:4] |
| wait_en | input | 1 | Enables two wait states per window access |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| io_wait | output | 1 | Wait request to the bus |
| cp_done | input | 1 | Command completion pulse |
| cp_flags | input | 5 | Status flags for bits 6:2, loaded on cp_done |
| cp_err | input | 8 | Error code, loaded on cp_done |
| cp_irq | input | 1 | Interrupt request pulse |
| cmd_go | output | 1 | One-cycle command issue pulse |
| cmd_code | output | 8 | Last accepted command byte |
| irq | output | 1 | Latched interrupt request |
| sec_cnt | output | 8 | Sector count register |
| sec_num | output | 8 | Sector number register |
| cyl | output | 10 | Cylinder number |
| ecc_sel | output | 1 | ECC (1) or CRC (0) |
| sec_len | output | 11 | Sector length in bytes |
| drv_sel | output | 4 | One-hot drive select |
| head | output | 3 | Head number |
| precomp_on | output | 1 | Write precompensation active |
| dma_addr | output | 24 | DMA start address |
| ctrl_port | output | 8 | Control byte |

## Verification
Every register, the read data, cmd_go and busy change on the clock edge that samples the strobe or pulse, so the bench drives at the falling edge and reads all results at the next falling edge, one edge later. io_wait is due in the two falling-edge samples after the strobe and must be low at the third, which the bench samples one by one. Decoded outputs such as sec_len, drv_sel and precomp_on follow combinationally from registers and are checked in the same sample as the write that loads them.

// File: rtl/dskhost_pkg.sv
package dskhost_pkg;

  localparam int BYTE_W = 8;

  localparam int OFS_DATA  = 0;
  localparam int OFS_ERRPC = 1;
  localparam int OFS_SCNT  = 2;
  localparam int OFS_SNUM  = 3;
  localparam int OFS_CYLL  = 4;
  localparam int OFS_CYLH  = 5;
  localparam int OFS_SDH   = 6;
  localparam int OFS_STCMD = 7;
  localparam int OFS_DMA0  = 8;
  localparam int OFS_CTRL  = 11;

  // sector length in bytes from the two size bits
  function automatic logic [10:0] size_to_len(input logic [1:0] code);
    case (code)
      2'b00:   size_to_len = 11'd256;
      2'b01:   size_to_len = 11'd512;
      2'b10:   size_to_len = 11'd1024;
      default: size_to_len = 11'd128;
    endcase
  endfunction

  function automatic logic [3:0] drive_onehot(input logic [1:0] code);
    drive_onehot = 4'(1) << code;
  endfunction

  // precompensation compares against the stored value times four
  function automatic logic precomp_hit(input logic [9:0] cyl_v,
                                       input logic [7:0] pc_v);
    precomp_hit = (cyl_v >= {pc_v, 2'b00});
  endfunction

endpackage

// File: rtl/dskhost_decode.sv
module dskhost_decode #(
  parameter int ADDR_W      = 8,
  parameter int BASE_W      = 4,
  parameter int WAIT_STATES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BASE_W-1:0]        base_sel,
  input  logic                     wait_en,
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic                     io_rd,
  input  logic                     io_wr,
  output logic [ADDR_W-BASE_W-1:0] ofs,
  output logic                     hit_acc,
  output logic                     rd_acc,
  output logic                     wr_acc,
  output logic                     io_wait
);
  localparam int OFS_W = ADDR_W - BASE_W;
  localparam int WCW   = $clog2(WAIT_STATES + 1);

  logic           hit;
  logic [WCW-1:0] wcnt;

  assign hit     = (io_addr[ADDR_W-1:OFS_W] == base_sel);
  assign ofs     = io_addr[OFS_W-1:0];
  assign rd_acc  = hit && io_rd;
  assign wr_acc  = hit && io_wr;
  assign hit_acc = rd_acc || wr_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (hit_acc && wait_en) begin
      wcnt <= WCW'(WAIT_STATES);
    end else if (wcnt != '0) begin
      wcnt <= wcnt - WCW'(1);
    end
  end

  assign io_wait = (wcnt != '0);
endmodule

// File: rtl/dskhost_secbuf.sv
module dskhost_secbuf #(
  parameter int BUF_DEPTH = 1024,
  parameter int PTR_W     = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             we,
  input  logic [7:0]       wdata,
  input  logic             clr,
  output logic [7:0]       rdata,
  output logic [PTR_W-1:0] ptr
);
  logic [7:0] mem [BUF_DEPTH];

  always_ff @(posedge clk) begin
    if (acc && we) begin
      mem[ptr] <= wdata;
    end
  end

  assign rdata = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (acc) begin
      ptr <= (ptr == PTR_W'(BUF_DEPTH - 1)) ? '0 : ptr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/dskhost_taskregs.sv
module dskhost_taskregs
  import dskhost_pkg::*;
#(
  parameter int OFS_W     = 4,
  parameter int DMA_BYTES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_acc,
  input  logic                     wr_acc,
  input  logic [OFS_W-1:0]         ofs,
  input  logic [7:0]               wdata,
  input  logic                     cp_done,
  input  logic [4:0]               cp_flags,
  input  logic [7:0]               cp_err,
  input  logic                     cp_irq,
  output logic [7:0]               precomp_q,
  output logic [7:0]               scnt_q,
  output logic [7:0]               snum_q,
  output logic [7:0]               cyll_q,
  output logic [7:0]               cylh_q,
  output logic [7:0]               sdh_q,
  output logic [7:0]               err_q,
  output logic [7:0]               status_q,
  output logic                     busy,
  output logic                     irq,
  output logic                     cmd_go,
  output logic [7:0]               cmd_code,
  output logic [8*DMA_BYTES-1:0]   dma_addr,
  output logic [7:0]               ctrl_q,
  output logic                     cmd_acc,
  output logic                     stat_rd,
  output logic                     blk_wr
);
  logic       task_wr;
  logic       task_ok;
  logic       err_bit;
  logic [4:0] flags_q;

  assign task_wr = wr_acc && (ofs >= OFS_W'(OFS_ERRPC)) && (ofs <= OFS_W'(OFS_SDH));
  assign task_ok = task_wr && !busy;
  assign cmd_acc = wr_acc && (ofs == OFS_W'(OFS_STCMD)) && !busy;
  assign stat_rd = rd_acc && (ofs == OFS_W'(OFS_STCMD));
  assign blk_wr  = busy && (task_wr || (wr_acc && ofs == OFS_W'(OFS_STCMD)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      precomp_q <= '0;
      scnt_q    <= '0;
      snum_q    <= '0;
      cyll_q    <= '0;
      cylh_q    <= '0;
      sdh_q     <= '0;
    end else if (task_ok) begin
      case (ofs)
        OFS_W'(OFS_ERRPC): precomp_q <= wdata;
        OFS_W'(OFS_SCNT):  scnt_q    <= wdata;
        OFS_W'(OFS_SNUM):  snum_q    <= wdata;
        OFS_W'(OFS_CYLL):  cyll_q    <= wdata;
        OFS_W'(OFS_CYLH):  cylh_q    <= wdata;
        default:           sdh_q     <= wdata;
      endcase
    end
  end

  for (genvar i = 0; i < DMA_BYTES; i++) begin : g_dma
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (wr_acc && ofs == OFS_W'(OFS_DMA0 + i)) begin
        byte_q <= wdata;
      end
    end
    assign dma_addr[8*i +: 8] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_acc && ofs == OFS_W'(OFS_CTRL)) begin
      ctrl_q <= wdata;
    end
  end

  // command handshake: a new command overrides a same-cycle completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err_bit  <= 1'b0;
      flags_q  <= '0;
      err_q    <= '0;
      cmd_go   <= 1'b0;
      cmd_code <= '0;
    end else begin
      cmd_go <= 1'b0;
      if (cp_done) begin
        busy    <= 1'b0;
        flags_q <= cp_flags;
        err_q   <= cp_err;
        err_bit <= (cp_err != '0);
      end
      if (cmd_acc) begin
        busy     <= 1'b1;
        err_bit  <= 1'b0;
        cmd_go   <= 1'b1;
        cmd_code <= wdata;
      end
    end
  end

  // interrupt latch: a request wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (cp_irq) begin
      irq <= 1'b1;
    end else if (cmd_acc || stat_rd) begin
      irq <= 1'b0;
    end
  end

  assign status_q = {busy, flags_q, 1'b0, err_bit};
endmodule

// File: rtl/dskhost_regif.sv
module dskhost_regif
  import dskhost_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BASE_W      = 4,
  parameter int BUF_DEPTH   = 1024,
  parameter int WAIT_STATES = 2,
  parameter int DMA_BYTES   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BASE_W-1:0]      base_sel,
  input  logic                   wait_en,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   io_rd,
  input  logic                   io_wr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   io_wait,
  input  logic                   cp_done,
  input  logic [4:0]             cp_flags,
  input  logic [7:0]             cp_err,
  input  logic                   cp_irq,
  output logic                   cmd_go,
  output logic [7:0]             cmd_code,
  output logic                   irq,
  output logic [7:0]             sec_cnt,
  output logic [7:0]             sec_num,
  output logic [9:0]             cyl,
  output logic                   ecc_sel,
  output logic [10:0]            sec_len,
  output logic [3:0]             drv_sel,
  output logic [2:0]             head,
  output logic                   precomp_on,
  output logic [8*DMA_BYTES-1:0] dma_addr,
  output logic [7:0]             ctrl_port
);
  localparam int OFS_W = ADDR_W - BASE_W;
  localparam int PTR_W = $clog2(BUF_DEPTH);

  logic [OFS_W-1:0] ofs;
  logic             hit_acc, rd_acc, wr_acc;
  logic             buf_acc;
  logic [7:0]       buf_rdata;
  logic [PTR_W-1:0] buf_ptr;
  logic             ptr_zero;
  logic [7:0]       precomp_q, cyll_q, cylh_q, sdh_q, err_q, status_q;
  logic             busy, cmd_acc, stat_rd, blk_wr;
  logic [7:0]       rd_mux;

  dskhost_decode #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .WAIT_STATES(WAIT_STATES)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .wait_en(wait_en),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .ofs(ofs),
    .hit_acc(hit_acc), .rd_acc(rd_acc), .wr_acc(wr_acc), .io_wait(io_wait)
  );

  assign buf_acc = (rd_acc || wr_acc) && (ofs == OFS_W'(OFS_DATA));

  dskhost_secbuf #(.BUF_DEPTH(BUF_DEPTH), .PTR_W(PTR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .acc(buf_acc), .we(wr_acc), .wdata(io_wdata),
    .clr(cmd_acc), .rdata(buf_rdata), .ptr(buf_ptr)
  );

  assign ptr_zero = (buf_ptr == '0);

  dskhost_taskregs #(.OFS_W(OFS_W), .DMA_BYTES(DMA_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .wr_acc(wr_acc), .ofs(ofs),
    .wdata(io_wdata), .cp_done(cp_done), .cp_flags(cp_flags), .cp_err(cp_err),
    .cp_irq(cp_irq), .precomp_q(precomp_q), .scnt_q(sec_cnt), .snum_q(sec_num),
    .cyll_q(cyll_q), .cylh_q(cylh_q), .sdh_q(sdh_q), .err_q(err_q),
    .status_q(status_q), .busy(busy), .irq(irq), .cmd_go(cmd_go),
    .cmd_code(cmd_code), .dma_addr(dma_addr), .ctrl_q(ctrl_port),
    .cmd_acc(cmd_acc), .stat_rd(stat_rd), .blk_wr(blk_wr)
  );

  always_comb begin
    case (ofs)
      OFS_W'(OFS_DATA):  rd_mux = buf_rdata;
      OFS_W'(OFS_ERRPC): rd_mux = err_q;
      OFS_W'(OFS_SCNT):  rd_mux = sec_cnt;
      OFS_W'(OFS_SNUM):  rd_mux = sec_num;
      OFS_W'(OFS_CYLL):  rd_mux = cyll_q;
      OFS_W'(OFS_CYLH):  rd_mux = cylh_q;
      OFS_W'(OFS_SDH):   rd_mux = sdh_q;
      OFS_W'(OFS_STCMD): rd_mux = status_q;
      default:           rd_mux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rdata <= '0;
    end else if (rd_acc) begin
      io_rdata <= rd_mux;
    end
  end

  assign cyl        = {cylh_q[1:0], cyll_q};
  assign ecc_sel    = sdh_q[7];
  assign sec_len    = size_to_len(sdh_q[6:5]);
  assign drv_sel    = drive_onehot(sdh_q[4:3]);
  assign head       = sdh_q[2:0];
  assign precomp_on = precomp_hit(cyl, precomp_q);
endmodule

// File: rtl/dskhost_regif_chk.sv
module dskhost_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_acc,
  input logic       stat_rd,
  input logic       blk_wr,
  input logic       hit_acc,
  input logic       cp_irq,
  input logic       irq,
  input logic       busy,
  input logic       cmd_go,
  input logic       io_wait,
  input logic       ptr_zero,
  input logic [7:0] status_q,
  input logic [7:0] sec_cnt
);
  p_busy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> (busy && cmd_go));

  p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> ptr_zero);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> !status_q[0]);

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_irq |=> irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_acc || stat_rd) && !cp_irq) |=> !irq);

  p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr |=> ($stable(sec_cnt) && !cmd_go));

  p_wait_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_wait) |=> io_wait);

  p_wait_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_wait) |-> $past(hit_acc));

  p_stat_bit1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[1]);
endmodule

bind dskhost_regif dskhost_regif_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc), .stat_rd(stat_rd),
  .blk_wr(blk_wr), .hit_acc(hit_acc), .cp_irq(cp_irq), .irq(irq),
  .busy(busy), .cmd_go(cmd_go), .io_wait(io_wait), .ptr_zero(ptr_zero),
  .status_q(status_q), .sec_cnt(sec_cnt)
);

// File: tb/dskhost_regif_tb_top.sv
module dskhost_regif_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] BASE = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  base_sel = BASE;
  logic        wait_en = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_wait;
  logic        cp_done = 1'b0;
  logic [4:0]  cp_flags = '0;
  logic [7:0]  cp_err = '0;
  logic        cp_irq = 1'b0;
  logic        cmd_go;
  logic [7:0]  cmd_code;
  logic        irq;
  logic [7:0]  sec_cnt, sec_num;
  logic [9:0]  cyl;
  logic        ecc_sel;
  logic [10:0] sec_len;
  logic [3:0]  drv_sel;
  logic [2:0]  head;
  logic        precomp_on;
  logic [23:0] dma_addr;
  logic [7:0]  ctrl_port;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dskhost_regif dut_i (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .wait_en(wait_en),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_wait(io_wait), .cp_done(cp_done),
    .cp_flags(cp_flags), .cp_err(cp_err), .cp_irq(cp_irq), .cmd_go(cmd_go),
    .cmd_code(cmd_code), .irq(irq), .sec_cnt(sec_cnt), .sec_num(sec_num),
    .cyl(cyl), .ecc_sel(ecc_sel), .sec_len(sec_len), .drv_sel(drv_sel),
    .head(head), .precomp_on(precomp_on), .dma_addr(dma_addr),
    .ctrl_port(ctrl_port)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called and returning at a falling edge; results sampled one edge later
  task automatic acc(input bit wr, input logic [7:0] a, input logic [7:0] d,
                     output logic [7:0] q);
    io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
    @(posedge clk); @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    q = io_rdata;
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b1, {BASE, o}, d, q);
  endtask

  task automatic rd(input logic [3:0] o, output logic [7:0] q);
    acc(1'b0, {BASE, o}, 8'h00, q);
  endtask

  task automatic done(input logic [4:0] f, input logic [7:0] e);
    cp_done = 1'b1; cp_flags = f; cp_err = e;
    @(posedge clk); @(negedge clk);
    cp_done = 1'b0;
  endtask

  task automatic pulse_irq();
    cp_irq = 1'b1;
    @(posedge clk); @(negedge clk);
    cp_irq = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] q, q2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'd7, q); chk("R2 reset status", q, 8'h00);
    chk("R9 reset irq", irq, 0);
    chk("R11 reset sec_len", sec_len, 256);
    chk("R11 reset drv_sel", drv_sel, 4'b0001);
    chk("R13 reset wait", io_wait, 0);

    // R2/R3 read and write maps
    for (int o = 2; o <= 6; o++) wr(4'(o), 8'(8'h10 * o + 1));
    for (int o = 2; o <= 6; o++) begin
      rd(4'(o), q); chk("R2 task readback", q, 8'h10 * o + 1);
    end
    wr(4'd1, 8'h55);
    rd(4'd1, q); chk("R3 offset1 reads error not precomp", q, 8'h00);
    for (int o = 8; o <= 15; o++) begin
      rd(4'(o), q); chk("R2 unreadable offset", q, 8'hFF);
    end
    wr(4'd8, 8'h12); wr(4'd9, 8'h34); wr(4'd10, 8'h56); wr(4'd11, 8'h9C);
    chk("R3 dma_addr", dma_addr, 24'h563412);
    chk("R3 ctrl", ctrl_port, 8'h9C);
    for (int o = 12; o <= 15; o++) wr(4'(o), 8'hEE);
    chk("R3 unused dma", dma_addr, 24'h563412);
    chk("R3 unused ctrl", ctrl_port, 8'h9C);
    for (int o = 2; o <= 6; o++) begin
      rd(4'(o), q); chk("R3 unused leaves task regs", q, 8'h10 * o + 1);
    end

    // R1 decode sweep over every other base
    wait_en = 1'b1;
    for (int b = 0; b < 16; b++) begin
      if (b == BASE) continue;
      rd(4'd2, q2);
      repeat (3) @(negedge clk);
      acc(1'b1, {4'(b), 4'd2}, 8'hEE, q);
      chk("R1 miss no wait", io_wait, 0);
      acc(1'b0, {4'(b), 4'd7}, 8'h00, q);
      chk("R1 miss rdata held", q, q2);
      chk("R1 miss no write", sec_cnt, 8'h21);
    end

    // R13 wait states on an unused offset
    wr(4'd13, 8'h00);
    chk("R13 wait first", io_wait, 1);
    @(negedge clk); chk("R13 wait second", io_wait, 1);
    @(negedge clk); chk("R13 wait released", io_wait, 0);
    wait_en = 1'b0;
    wr(4'd2, 8'h21);
    chk("R13 wait disabled", io_wait, 0);

    // R11 size/drive/head sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd6, 8'(v));
      chk("R11 ecc", ecc_sel, (v >> 7) & 1);
      chk("R11 len", sec_len, (((v >> 5) & 3) == 3) ? 128 : (256 << ((v >> 5) & 3)));
      case ((v >> 3) & 3)
        0: chk("R11 drive", drv_sel, 4'b0001);
        1: chk("R11 drive", drv_sel, 4'b0010);
        2: chk("R11 drive", drv_sel, 4'b0100);
        default: chk("R11 drive", drv_sel, 4'b1000);
      endcase
      chk("R11 head", head, v % 8);
    end

    // R12 cylinder and precompensation
    for (int p = 0; p < 256; p += 51) begin
      wr(4'd1, 8'(p));
      for (int c = 0; c < 1024; c += 37) begin
        wr(4'd4, 8'(c % 256)); wr(4'd5, 8'(8'hFC | (c / 256)));
        chk("R12 cyl", cyl, c);
        chk("R12 precomp", precomp_on, (c / 4) >= p);
      end
      if (p > 0) begin
        wr(4'd4, 8'((p * 4 - 1) % 256)); wr(4'd5, 8'((p * 4 - 1) / 256));
        chk("R12 below edge", precomp_on, 0);
        wr(4'd4, 8'((p * 4) % 256)); wr(4'd5, 8'((p * 4) / 256));
        chk("R12 at edge", precomp_on, 1);
      end
    end

    // R4/R5 sector buffer
    wr(4'd7, 8'h01); done(5'd0, 8'd0);
    for (int i = 0; i < 1024; i++) wr(4'd0, pat(i));
    wr(4'd7, 8'h02); done(5'd0, 8'd0);
    for (int i = 0; i < 1024; i++) begin
      rd(4'd0, q); chk("R4 buffer readback", q, pat(i));
    end
    rd(4'd0, q); chk("R4 pointer wraps", q, pat(0));
    rd(4'd0, q); rd(4'd0, q);
    wr(4'd7, 8'h03); done(5'd0, 8'd0);
    rd(4'd0, q); chk("R5 command clears pointer", q, pat(0));

    // R6 command issue and busy
    wr(4'd7, 8'h20);
    chk("R6 cmd_go", cmd_go, 1);
    chk("R6 cmd_code", cmd_code, 8'h20);
    rd(4'd7, q); chk("R6 busy in status", q[7], 1);
    chk("R6 cmd_go single", cmd_go, 0);

    // R7 writes ignored while busy
    wr(4'd2, 8'h99);
    rd(4'd2, q); chk("R7 task write ignored", q, 8'h21);
    wr(4'd7, 8'h30);
    chk("R7 no second cmd_go", cmd_go, 0);
    chk("R7 cmd_code kept", cmd_code, 8'h20);

    // R8 completion
    done(5'b10011, 8'h10);
    rd(4'd7, q); chk("R8 status after done", q, 8'h4D);
    rd(4'd1, q); chk("R8 error code", q, 8'h10);
    wr(4'd2, 8'h77);
    rd(4'd2, q); chk("R8 writes accepted when idle", q, 8'h77);

    // R10 command clears error bit, flags stay
    wr(4'd7, 8'h40);
    rd(4'd7, q); chk("R10 error bit cleared", q, 8'hCC);
    done(5'd0, 8'd0);
    rd(4'd7, q); chk("R8 zero code no error", q, 8'h00);

    // R9 interrupt latch
    pulse_irq();
    chk("R9 irq set", irq, 1);
    repeat (3) @(negedge clk);
    chk("R9 irq held", irq, 1);
    rd(4'd7, q); chk("R9 status read clears", irq, 0);
    pulse_irq();
    wr(4'd7, 8'h50); chk("R9 command clears", irq, 0);
    done(5'd0, 8'd0);
    cp_irq = 1'b1; io_addr = {BASE, 4'd7}; io_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    cp_irq = 1'b0; io_rd = 1'b0;
    chk("R9 set wins over clear", irq, 1);
    rd(4'd3, q); chk("R9 other read keeps irq", irq, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule